// File: doc/BRIEF.md
# Toggle Bit Polling Controller

This block sits on the host side of a parallel flash bus and decides when a program or erase operation inside the flash has finished. After a one-cycle start pulse it reads the device status byte twice in a row through a request/acknowledge read port. It then compares the toggle bit between the two reads. A status bit that stays put means the internal operation has ended. A bit that keeps flipping means the operation is still running.

When the bit flips and the device's time-limit flag in the latest byte is clear, the controller simply polls again. When the time-limit flag is set, it takes one more pair of reads. The toggle can stop in the same instant the flag rises, so the extra pair decides between success and failure. On failure the controller writes a reset command through a separate request/acknowledge port. It then pulses `fail_o`. On success it pulses `done_o`. An optional cap on the number of polling pairs stops the controller from hanging on a device that never settles.

The read address, the bus cycle timing and the reset command encoding are all supplied outside this block. Status reads may target any address.

Top module: `tbp_poll_ctrl`

## Requirements
- R1: A start pulse accepted in idle makes the controller issue status reads. Reads come in pairs, one read at a time. `rd_req_o` stays high until a cycle with `rd_ack_i` high, and `rd_data_i` is captured in that cycle.
- R2: If data bit 6 (`TOGGLE_IDX`) is equal in both reads of a polling pair, the controller pulses `done_o` and writes no reset command. This holds whatever the value of bit 5.
- R3: If bit 6 differs within a pair and bit 5 (`TIMEOUT_IDX`) of the second read is 0, the controller issues another pair of reads.
- R4: If bit 6 differs within a pair and bit 5 of the second read is 1, the controller issues one recheck pair. If bit 6 is equal within the recheck pair, it pulses `done_o`.
- R5: If bit 6 still differs within the recheck pair, the controller holds `rst_cmd_req_o` high until `rst_cmd_ack_i`. It pulses `fail_o` in the cycle after the acknowledge.
- R6: `done_o` and `fail_o` are single-cycle pulses and never both high. `busy_o` is high from the cycle after an accepted start until the pulse cycle. In the pulse cycle the controller is idle, and a start in that cycle is accepted.
- R7: A start pulse while `busy_o` is high is ignored. No extra reads follow the result pulse.
- R8: With `MAX_POLLS` > 0, a polling pair counts toward the cap. If the `MAX_POLLS`-th pair toggles with bit 5 at 0, the controller writes the reset command and fails instead of polling again. A pair with bit 5 at 1 takes the recheck path even when it is the last pair, and the recheck pair does not count. With `MAX_POLLS` = 0 there is no cap.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start polling (honoured in idle only) |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Status read acknowledge, data valid |
| rd_data_i | input | DATA_W | Status byte returned by the read |
| rst_cmd_req_o | output | 1 | Reset command write request |
| rst_cmd_ack_i | input | 1 | Reset command write acknowledge |
| done_o | output | 1 | One-cycle pulse: operation complete |
| fail_o | output | 1 | One-cycle pulse: operation failed |
| busy_o | output | 1 | Poll in progress |

## Verification
A start request can coincide with the edge where a pair is judged, and there it must be ignored. It can also coincide with the result pulse, and there it must begin a new poll. The bench holds `start_i` high across several back-to-back polls so that both coincidences occur, and a behavioural reference model compares every output on every clock. The poll cap and the timeout flag can also land on the same pair. A script whose last counted pair carries bit 5 set checks that the recheck path wins and that the poll ends in `done_o` with no reset write.

// File: rtl/tbp_pkg.sv
`timescale 1ns/1ps
package tbp_pkg;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_POLL    = 2'd1,
      PH_RECHECK = 2'd2,
      PH_RSTCMD  = 2'd3
   } phase_t;

   typedef enum logic [1:0] {
      RD_IDLE   = 2'd0,
      RD_FIRST  = 2'd1,
      RD_SECOND = 2'd2
   } rdst_t;

   typedef struct packed {
      logic toggled;
      logic timeout;
   } pair_res_t;

endpackage

// File: rtl/tbp_read_pair.sv
`timescale 1ns/1ps
module tbp_read_pair
   import tbp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TOGGLE_IDX  = 6,
   parameter int TIMEOUT_IDX = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   output logic              rd_req_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              pair_done_o,
   output pair_res_t         res_o
);

   rdst_t     st_q, st_d;
   logic      first_bit_q;
   logic      done_q;
   pair_res_t res_q;
   logic      hs;
   logic      unused_bits;

   assign unused_bits = ^rd_data_i;
   assign hs          = rd_req_o & rd_ack_i;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         RD_IDLE:   if (go_i) st_d = RD_FIRST;
         RD_FIRST:  if (rd_ack_i) st_d = RD_SECOND;
         RD_SECOND: if (rd_ack_i) st_d = RD_IDLE;
         default:   st_d = RD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= RD_IDLE;
         first_bit_q <= 1'b0;
         done_q      <= 1'b0;
         res_q       <= '0;
      end else begin
         st_q   <= st_d;
         done_q <= 1'b0;
         if (hs && st_q == RD_FIRST) first_bit_q <= rd_data_i[TOGGLE_IDX];
         if (hs && st_q == RD_SECOND) begin
            res_q.toggled <= rd_data_i[TOGGLE_IDX] ^ first_bit_q;
            res_q.timeout <= rd_data_i[TIMEOUT_IDX];
            done_q        <= 1'b1;
         end
      end
   end

   assign rd_req_o    = (st_q != RD_IDLE);
   assign pair_done_o = done_q;
   assign res_o       = res_q;

   // R1: a pending read request stays up until acknowledged
   assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> rd_req_o);

   // R1: a new pair is only launched when no read is outstanding
   assert_go_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> (st_q == RD_IDLE));

   // R1: completion flag follows the second acknowledge
   assert_pair_after_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pair_done_o |-> $past(rd_ack_i));

endmodule

// File: rtl/tbp_poll_limit.sv
`timescale 1ns/1ps
module tbp_poll_limit #(
   parameter int MAX_POLLS = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);

   localparam int LIM   = (MAX_POLLS > 0) ? MAX_POLLS : 1;
   localparam int CNT_W = $clog2(LIM + 1);

   generate
      if (MAX_POLLS == 0) begin : g_unbounded
         logic unused_tie;
         assign unused_tie = ^{clk, rst_n, clr_i, inc_i};
         assign last_o     = 1'b0;
      end else begin : g_bounded
         logic [CNT_W-1:0] cnt_q;
         logic             at_last;

         assign at_last = (cnt_q == CNT_W'(LIM - 1));
         assign last_o  = at_last;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (clr_i)            cnt_q <= '0;
            else if (inc_i && !at_last) cnt_q <= cnt_q + 1'b1;
         end

         // R8: counter never runs past the configured cap
         assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q < CNT_W'(LIM));
      end
   endgenerate

endmodule

// File: rtl/tbp_seq.sv
`timescale 1ns/1ps
module tbp_seq
   import tbp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  logic      pair_done_i,
   input  pair_res_t res_i,
   input  logic      last_i,
   input  logic      cmd_ack_i,
   output logic      go_o,
   output logic      clr_o,
   output logic      inc_o,
   output logic      cmd_req_o,
   output logic      done_o,
   output logic      fail_o,
   output logic      busy_o,
   output phase_t    phase_o
);

   phase_t ph_q, ph_d;
   logic   done_d, fail_d, done_q, fail_q;

   always_comb begin
      ph_d   = ph_q;
      go_o   = 1'b0;
      clr_o  = 1'b0;
      inc_o  = 1'b0;
      done_d = 1'b0;
      fail_d = 1'b0;
      unique case (ph_q)
         PH_IDLE: begin
            if (start_i) begin
               ph_d  = PH_POLL;
               go_o  = 1'b1;
               clr_o = 1'b1;
            end
         end
         PH_POLL: begin
            if (pair_done_i) begin
               inc_o = 1'b1;
               if (!res_i.toggled) begin
                  done_d = 1'b1;
                  ph_d   = PH_IDLE;
               end else if (res_i.timeout) begin
                  go_o = 1'b1;
                  ph_d = PH_RECHECK;
               end else if (last_i) begin
                  ph_d = PH_RSTCMD;
               end else begin
                  go_o = 1'b1;
               end
            end
         end
         PH_RECHECK: begin
            if (pair_done_i) begin
               if (!res_i.toggled) begin
                  done_d = 1'b1;
                  ph_d   = PH_IDLE;
               end else begin
                  ph_d = PH_RSTCMD;
               end
            end
         end
         PH_RSTCMD: begin
            if (cmd_ack_i) begin
               fail_d = 1'b1;
               ph_d   = PH_IDLE;
            end
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         done_q <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         done_q <= done_d;
         fail_q <= fail_d;
      end
   end

   assign cmd_req_o = (ph_q == PH_RSTCMD);
   assign busy_o    = (ph_q != PH_IDLE);
   assign done_o    = done_q;
   assign fail_o    = fail_q;
   assign phase_o   = ph_q;

   // R6: result pulses last one cycle and are exclusive
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_fail_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |=> !fail_o);
   assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && fail_o));

   // R5: failure is reported only after the reset write was acknowledged
   assert_fail_after_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> $past(cmd_req_o && cmd_ack_i));

   // R5: reset write request holds until acknowledged
   assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && !cmd_ack_i) |=> cmd_req_o);

   // R7: a start while busy does not clear the cap counter
   assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !clr_o);

endmodule

// File: rtl/tbp_poll_ctrl.sv
`timescale 1ns/1ps
module tbp_poll_ctrl
   import tbp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TOGGLE_IDX  = 6,
   parameter int TIMEOUT_IDX = 5,
   parameter int MAX_POLLS   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              rd_req_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              rst_cmd_req_o,
   input  logic              rst_cmd_ack_i,
   output logic              done_o,
   output logic              fail_o,
   output logic              busy_o
);

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
      assert (TOGGLE_IDX >= 0 && TOGGLE_IDX < DATA_W) else $error("TOGGLE_IDX out of range");
      assert (TIMEOUT_IDX >= 0 && TIMEOUT_IDX < DATA_W) else $error("TIMEOUT_IDX out of range");
      assert (TOGGLE_IDX != TIMEOUT_IDX) else $error("status bit indices must differ");
      assert (MAX_POLLS >= 0) else $error("MAX_POLLS must not be negative");
   end

   logic      go, clr, inc, last, pair_done;
   pair_res_t res;
   phase_t    phase;

   tbp_read_pair #(
      .DATA_W     (DATA_W),
      .TOGGLE_IDX (TOGGLE_IDX),
      .TIMEOUT_IDX(TIMEOUT_IDX)
   ) u_pair (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (go),
      .rd_req_o   (rd_req_o),
      .rd_ack_i   (rd_ack_i),
      .rd_data_i  (rd_data_i),
      .pair_done_o(pair_done),
      .res_o      (res)
   );

   tbp_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr),
      .inc_i (inc),
      .last_o(last)
   );

   tbp_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .pair_done_i(pair_done),
      .res_i      (res),
      .last_i     (last),
      .cmd_ack_i  (rst_cmd_ack_i),
      .go_o       (go),
      .clr_o      (clr),
      .inc_o      (inc),
      .cmd_req_o  (rst_cmd_req_o),
      .done_o     (done_o),
      .fail_o     (fail_o),
      .busy_o     (busy_o)
      ,.phase_o   (phase)
   );

   // R7: no status read is outstanding while the sequencer is idle
   assert_idle_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !rd_req_o);

   // R4: a toggling pair with the time-limit flag set leads to a recheck
   assert_recheck_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_done && phase == PH_POLL && res.toggled && res.timeout) |=> (phase == PH_RECHECK));

   // R3: a toggling pair with the flag clear keeps polling or hits the cap
   assert_repoll_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_done && phase == PH_POLL && res.toggled && !res.timeout)
         |=> (rd_req_o || rst_cmd_req_o));

   // R2: a steady pair never leads to a reset write
   assert_steady_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_done && !res.toggled && phase != PH_IDLE) |=> (done_o && !rst_cmd_req_o));

endmodule

// File: tb/tbp_poll_ctrl_test.sv
`timescale 1ns/1ps
module tbp_poll_ctrl_test;

   localparam int MAXP = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       rd_ack_i = 1'b0;
   logic [7:0] rd_data_i = 8'h00;
   logic       rst_cmd_ack_i = 1'b0;
   logic       rd_req_o, rst_cmd_req_o, done_o, fail_o, busy_o;

   tbp_poll_ctrl #(.DATA_W(8), .TOGGLE_IDX(6), .TIMEOUT_IDX(5), .MAX_POLLS(MAXP)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
      .rst_cmd_req_o(rst_cmd_req_o), .rst_cmd_ack_i(rst_cmd_ack_i),
      .done_o(done_o), .fail_o(fail_o), .busy_o(busy_o)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- device model ----------------
   logic [7:0] scr[$];
   int ptr = 0;
   int reads = 0;
   int cmds = 0;
   int rd_wait = 0;
   int rd_left = 0;
   int cmd_left = 0;
   int n_done = 0;
   int n_fail = 0;

   always @(negedge clk) begin
      if (rd_ack_i) begin
         rd_ack_i <= 1'b0;
         ptr      <= ptr + 1;
         reads    <= reads + 1;
         rd_left  <= rd_wait;
      end else if (rd_req_o && rst_n) begin
         if (rd_left == 0) begin
            rd_ack_i  <= 1'b1;
            rd_data_i <= (ptr < scr.size()) ? scr[ptr] : 8'h00;
         end else begin
            rd_left <= rd_left - 1;
         end
      end
      if (rst_cmd_ack_i) begin
         rst_cmd_ack_i <= 1'b0;
         cmds          <= cmds + 1;
         cmd_left      <= 2;
      end else if (rst_cmd_req_o && rst_n) begin
         if (cmd_left == 0) rst_cmd_ack_i <= 1'b1;
         else cmd_left <= cmd_left - 1;
      end
      if (done_o) n_done <= n_done + 1;
      if (fail_o) n_fail <= n_fail + 1;
   end

   // ---------------- reference model ----------------
   int m_mode = 0;   // 0 idle, 1 poll, 2 recheck, 3 reset write
   int m_rd = 0;     // 0 none, 1 first read, 2 second read
   int m_pairs = 0;
   bit m_pend = 0, m_b6 = 0, m_tog = 0, m_to = 0, m_done = 0, m_fail = 0;

   always @(posedge clk) begin
      bit decide, nd, nf, last;
      if (!rst_n) begin
         m_mode = 0; m_rd = 0; m_pairs = 0; m_pend = 0; m_done = 0; m_fail = 0;
      end else begin
         nd = 0; nf = 0;
         decide = m_pend;
         m_pend = 0;
         if (m_rd == 1 && rd_ack_i) begin
            m_b6 = rd_data_i[6];
            m_rd = 2;
         end else if (m_rd == 2 && rd_ack_i) begin
            m_tog  = (rd_data_i[6] != m_b6);
            m_to   = rd_data_i[5];
            m_rd   = 0;
            m_pend = 1;
         end
         case (m_mode)
            0: if (start_i) begin m_mode = 1; m_rd = 1; m_pairs = 0; end
            1: if (decide) begin
                  last = (m_pairs == MAXP - 1);
                  m_pairs++;
                  if (!m_tog) begin nd = 1; m_mode = 0; end
                  else if (m_to) begin m_mode = 2; m_rd = 1; end
                  else if (last) m_mode = 3;
                  else m_rd = 1;
               end
            2: if (decide) begin
                  if (!m_tog) begin nd = 1; m_mode = 0; end
                  else m_mode = 3;
               end
            default: if (rst_cmd_ack_i) begin nf = 1; m_mode = 0; end
         endcase
         m_done = nd;
         m_fail = nf;
      end
   end

   // per-clock comparison
   always @(negedge clk) begin
      if (rst_n && cyc > 2) begin
         chk(rd_req_o == (m_rd != 0), "R1", "rd_req_o", rd_req_o, int'(m_rd != 0));
         chk(rst_cmd_req_o == (m_mode == 3), "R5", "rst_cmd_req_o", rst_cmd_req_o, int'(m_mode == 3));
         chk(done_o == m_done, "R2", "done_o", done_o, m_done);
         chk(fail_o == m_fail, "R5", "fail_o", fail_o, m_fail);
         chk(busy_o == (m_mode != 0), "R6", "busy_o", busy_o, int'(m_mode != 0));
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- directed cases ----------------
   task automatic run_case(input string req, input bit exp_fail, input int exp_reads,
                           input int wait_cfg, input bit mid_start);
      int d0, f0, r0, c0;
      bit seen;
      rd_wait = wait_cfg;
      @(negedge clk);
      ptr = 0;
      d0 = n_done; f0 = n_fail; r0 = reads; c0 = cmds;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (mid_start) begin
         @(negedge clk);
         start_i = 1'b1;   // R7: start while busy
         @(negedge clk);
         start_i = 1'b0;
      end
      seen = 0;
      for (int i = 0; i < 2000 && !seen; i++) begin
         @(negedge clk);
         if (done_o || fail_o) seen = 1;
      end
      chk(seen, req, "result pulse seen", seen, 1);
      chk(fail_o == exp_fail, req, "fail outcome", fail_o, exp_fail);
      chk(done_o == !exp_fail, req, "done outcome", done_o, int'(!exp_fail));
      repeat (8) @(negedge clk);
      chk((reads - r0) == exp_reads, req, "status reads", reads - r0, exp_reads);
      chk((cmds - c0) == int'(exp_fail), req, "reset writes", cmds - c0, int'(exp_fail));
      chk((n_done - d0) + (n_fail - f0) == 1, "R7", "result pulses", (n_done - d0) + (n_fail - f0), 1);
      chk(busy_o == 1'b0, "R7", "busy after result", busy_o, 0);
   endtask

   initial begin
      int d0, r0;
      repeat (3) @(negedge clk);
      chk({rd_req_o, rst_cmd_req_o, done_o, fail_o, busy_o} == 5'b0, "R9", "outputs in reset",
          {rd_req_o, rst_cmd_req_o, done_o, fail_o, busy_o}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      scr = '{8'h00, 8'h00};
      run_case("R2", 0, 2, 0, 0);                       // steady immediately
      scr = '{8'h20, 8'h20};
      run_case("R2", 0, 2, 1, 0);                       // bit5 set but no toggle
      scr = '{8'h40, 8'h00, 8'h00, 8'h00};
      run_case("R3", 0, 4, 2, 0);                       // one repoll
      scr = '{8'h40, 8'h00, 8'h00, 8'h00};
      run_case("R7", 0, 4, 1, 1);                       // start while busy
      scr = '{8'h00, 8'h60, 8'h40, 8'h40};
      run_case("R4", 0, 4, 0, 0);                       // recheck passes
      scr = '{8'h00, 8'h60, 8'h40, 8'h00};
      run_case("R5", 1, 4, 1, 0);                       // recheck still toggles
      scr = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40};
      run_case("R8", 1, 6, 0, 0);                       // cap reached
      scr = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h60, 8'h20, 8'h20};
      run_case("R8", 0, 8, 0, 0);                       // cap and timeout on same pair

      // R6: start held high across back-to-back polls
      scr = '{};
      rd_wait = 0;
      @(negedge clk);
      ptr = 0; d0 = n_done; r0 = reads;
      start_i = 1'b1;
      repeat (30) @(negedge clk);
      start_i = 1'b0;
      repeat (12) @(negedge clk);
      chk((n_done - d0) >= 3, "R6", "back-to-back done pulses", n_done - d0, 3);
      chk((reads - r0) == 2 * (n_done - d0), "R6", "two reads per poll", reads - r0, 2 * (n_done - d0));
      chk(busy_o == 1'b0, "R6", "idle after release", busy_o, 0);

      // R9: reset in the middle of a poll
      scr = '{8'h00, 8'h40, 8'h00, 8'h40};
      @(negedge clk);
      ptr = 0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk({rd_req_o, rst_cmd_req_o, done_o, fail_o, busy_o} == 5'b0, "R9", "outputs after mid-poll reset",
          {rd_req_o, rst_cmd_req_o, done_o, fail_o, busy_o}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule